// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a descriptor-driven packet DMA. Software first fills a table of descriptors. Each descriptor holds the base address of a receive buffer, and a status word that starts out holding the buffer size with the hardware-ownership bit set. Incoming frames arrive as a byte stream. The block writes each frame into the buffer of the descriptor selected by the low bits of a 16-bit producer index. It then rewrites that descriptor's status with the stored length and frame-boundary flags, and advances the producer index.

Software hands buffers back by writing a 16-bit consumer index. The distance from the consumer index to the producer index is the number of descriptors in use. When every descriptor is in use, a new frame is absorbed and thrown away, and a drop counter counts it. A pause request output, with hysteresis, follows the number of free descriptors. An optional two-byte pad can be placed ahead of the frame data so that the header that follows lands on an aligned boundary. The pad is counted in the reported length.

Top module: `rx_ring_writer`

## Requirements
- R1: Writing descriptor i through the preload port stores its buffer address and sets its status word to BUF_BYTES in bits 27:16, bit 15 (hardware owns) set, and all other bits 0.
- R2: With `align_en` high at frame start, two bytes of value 0 are written at buffer offsets 0 and 1, and frame byte k goes to offset k+2. With `align_en` low, frame byte k goes to offset k.
- R3: When a frame completes, its descriptor status is rewritten as follows: bits 27:16 hold the bytes stored including the pad; bits 14 (end of packet) and 13 (start of packet) are set; bit 15 is cleared. Then `prod_idx` rises by exactly one. The descriptor used is `prod_idx` modulo NUM_DESC.
- R4: Descriptors in use equal (`prod_idx` − consumer index) modulo 65536, where the consumer index is the last value written through `cons_wr_en`. Equal indices mean an empty ring. A descriptor freed by the consumer is reused when the producer reaches it again.
- R5: A frame that starts while NUM_DESC descriptors are in use is accepted and discarded. No buffer write happens, no descriptor changes, `prod_idx` stays unchanged, and `drop_cnt` rises by one.
- R6: `xoff` goes high one cycle after free descriptors fall to NUM_DESC/16 or below. Once high, it stays high until free descriptors exceed NUM_DESC/16 + RESUME_GAP.
- R7: Frame bytes beyond the buffer end are not written. The stored length is then BUF_BYTES and status bit 9 (truncated) is set. No write ever leaves the current buffer.
- R8: `ring_geom` reads {NUM_DESC, BUF_BYTES} in its upper and lower 16 bits. `fc_levels` reads {NUM_DESC/16, RESUME_GAP} in its upper and lower 16 bits.
- R9: After reset, the following are all 0: `prod_idx`, the consumer index, `drop_cnt`, `xoff`, `in_ready` and `mem_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| align_en | input | 1 | Insert two pad bytes before frame data (sampled at frame start) |
| dsc_wr_en | input | 1 | Preload one descriptor |
| dsc_wr_idx | input | IDX_W | Descriptor to preload |
| dsc_wr_addr | input | ADDR_W | Buffer base address for that descriptor |
| dsc_rd_idx | input | IDX_W | Descriptor to read back |
| dsc_rd_addr | output | ADDR_W | Buffer address of the read descriptor |
| dsc_rd_stat | output | 32 | Status word of the read descriptor |
| cons_wr_en | input | 1 | Load the consumer index |
| cons_wr_val | input | 16 | New consumer index |
| prod_idx | output | 16 | Producer index |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of frame |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| mem_wr_en | output | 1 | Buffer byte write strobe |
| mem_wr_addr | output | ADDR_W | Buffer byte address |
| mem_wr_data | output | 8 | Buffer byte value |
| xoff | output | 1 | Pause request |
| drop_cnt | output | 16 | Frames dropped for lack of a descriptor |
| ring_geom | output | 32 | Descriptor count and buffer size |
| fc_levels | output | 32 | Pause level and resume gap |

## Verification
The bench sweeps every frame length from 1 to 20 bytes, with and without the pad, on a ring of 32 descriptors of 16 bytes. This covers frames that fit, frames that fill the buffer exactly, and frames that overflow it by one or more bytes. Comparing the padded and unpadded runs separates offset errors from length-accounting errors. The sweep also carries the producer index around the ring, which exposes index-to-descriptor mapping faults.

A fill run then takes the ring from empty to full without consuming. It checks the pause output after every frame and sends one more frame to confirm the drop path. A drain run then returns buffers one at a time. Because it walks the whole band between the pause and resume levels, it tells a hysteresis fault apart from a plain threshold compare.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int LEN_LSB   = 16;
  localparam int LEN_W     = 12;
  localparam int OWN_BIT   = 15;
  localparam int EOP_BIT   = 14;
  localparam int SOP_BIT   = 13;
  localparam int TRUNC_BIT = 9;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_PAD  = 3'd1,
    SQ_DATA = 3'd2,
    SQ_DROP = 3'd3,
    SQ_DONE = 3'd4
  } seq_state_e;

  function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] len,
                                              input logic own,
                                              input logic bounds,
                                              input logic trunc);
    logic [31:0] s;
    s = '0;
    s[LEN_LSB +: LEN_W] = len;
    s[OWN_BIT]   = own;
    s[EOP_BIT]   = bounds;
    s[SOP_BIT]   = bounds;
    s[TRUNC_BIT] = trunc;
    return s;
  endfunction
endpackage

// File: rtl/rx_ring_desc_tab.sv
module rx_ring_desc_tab #(
  parameter int NUM_DESC = 256,
  parameter int ADDR_W   = 32,
  localparam int IDX_W   = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              sw_wr_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [31:0]       sw_stat,
  input  logic              hw_wr_en,
  input  logic [IDX_W-1:0]  hw_idx,
  input  logic [31:0]       hw_stat,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_stat,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [ADDR_W-1:0] addr_mem [NUM_DESC];
  logic [31:0]       stat_mem [NUM_DESC];

  // Storage array without reset; the completion write is ordered last so it
  // wins over a preload of the same entry in the same cycle.
  always_ff @(posedge clk) begin
    if (sw_wr_en) begin
      addr_mem[sw_idx] <= sw_addr;
      stat_mem[sw_idx] <= sw_stat;
    end
    if (hw_wr_en) begin
      stat_mem[hw_idx] <= hw_stat;
    end
  end

  assign rd_addr  = addr_mem[rd_idx];
  assign rd_stat  = stat_mem[rd_idx];
  assign cur_addr = addr_mem[cur_idx];
endmodule

// File: rtl/rx_ring_seq.sv
module rx_ring_seq
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 2048,
  localparam int OFF_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              align_en,
  input  logic              ring_full,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data,
  output logic              done_en,
  output logic [31:0]       done_stat,
  output logic              drop_pulse
);
  seq_state_e       state_q, state_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             trunc_q, trunc_d;
  logic             off_room;

  assign off_room = (off_q < OFF_W'(BUF_BYTES));

  always_comb begin
    state_d     = state_q;
    off_d       = off_q;
    trunc_d     = trunc_q;
    in_ready    = 1'b0;
    mem_wr_en   = 1'b0;
    mem_wr_data = in_data;
    done_en     = 1'b0;
    drop_pulse  = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (in_valid) begin
          off_d   = '0;
          trunc_d = 1'b0;
          if (ring_full)     state_d = SQ_DROP;
          else if (align_en) state_d = SQ_PAD;
          else               state_d = SQ_DATA;
        end
      end
      SQ_PAD: begin
        mem_wr_en   = 1'b1;
        mem_wr_data = 8'h00;
        off_d       = off_q + OFF_W'(1);
        if (off_q == OFF_W'(1)) state_d = SQ_DATA;
      end
      SQ_DATA: begin
        in_ready = 1'b1;
        if (in_valid) begin
          if (off_room) begin
            mem_wr_en = 1'b1;
            off_d     = off_q + OFF_W'(1);
          end else begin
            trunc_d = 1'b1;
          end
          if (in_last) state_d = SQ_DONE;
        end
      end
      SQ_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_last) begin
          drop_pulse = 1'b1;
          state_d    = SQ_IDLE;
        end
      end
      SQ_DONE: begin
        done_en = 1'b1;
        state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  assign mem_wr_addr = buf_addr + ADDR_W'(off_q);
  assign done_stat   = pack_status(LEN_W'(off_q), 1'b0, 1'b1, trunc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      off_q   <= '0;
      trunc_q <= 1'b0;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
      trunc_q <= trunc_d;
    end
  end
endmodule

// File: rtl/rx_ring_flow.sv
module rx_ring_flow #(
  parameter int NUM_DESC   = 256,
  parameter int RESUME_GAP = 5,
  localparam int IDX_W      = $clog2(NUM_DESC),
  localparam int CNT_W      = IDX_W + 1,
  localparam int PAUSE_LVL  = NUM_DESC / 16,
  localparam int RESUME_LVL = PAUSE_LVL + RESUME_GAP
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  input  logic        cons_wr_en,
  input  logic [15:0] cons_wr_val,
  input  logic        drop_pulse,
  output logic [15:0] prod_q,
  output logic [15:0] cons_q,
  output logic        ring_full,
  output logic        xoff_q,
  output logic [15:0] drop_q
);
  logic [15:0]      used;
  logic [CNT_W-1:0] free_cnt;
  logic             xoff_d;

  assign used      = prod_q - cons_q;
  assign ring_full = (used >= 16'(NUM_DESC));
  assign free_cnt  = CNT_W'(NUM_DESC) - used[CNT_W-1:0];

  always_comb begin
    if (xoff_q) xoff_d = (free_cnt <= CNT_W'(RESUME_LVL));
    else        xoff_d = (free_cnt <= CNT_W'(PAUSE_LVL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      cons_q <= '0;
      drop_q <= '0;
      xoff_q <= 1'b0;
    end else begin
      if (adv)        prod_q <= prod_q + 16'd1;
      if (cons_wr_en) cons_q <= cons_wr_val;
      if (drop_pulse) drop_q <= drop_q + 16'd1;
      xoff_q <= xoff_d;
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int NUM_DESC   = 256,
  parameter int BUF_BYTES  = 2048,
  parameter int ADDR_W     = 32,
  parameter int RESUME_GAP = 5,
  localparam int IDX_W     = $clog2(NUM_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              align_en,
  input  logic              dsc_wr_en,
  input  logic [IDX_W-1:0]  dsc_wr_idx,
  input  logic [ADDR_W-1:0] dsc_wr_addr,
  input  logic [IDX_W-1:0]  dsc_rd_idx,
  output logic [ADDR_W-1:0] dsc_rd_addr,
  output logic [31:0]       dsc_rd_stat,
  input  logic              cons_wr_en,
  input  logic [15:0]       cons_wr_val,
  output logic [15:0]       prod_idx,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data,
  output logic              xoff,
  output logic [15:0]       drop_cnt,
  output logic [31:0]       ring_geom,
  output logic [31:0]       fc_levels
);
  logic              ring_full;
  logic              done_en;
  logic [31:0]       done_stat;
  logic              drop_pulse;
  logic [15:0]       cons_idx;
  logic [IDX_W-1:0]  cur_idx;
  logic [ADDR_W-1:0] cur_buf_addr;
  logic [31:0]       preload_stat;

  assign cur_idx      = prod_idx[IDX_W-1:0];
  assign preload_stat = pack_status(LEN_W'(BUF_BYTES), 1'b1, 1'b0, 1'b0);
  assign ring_geom    = {16'(NUM_DESC), 16'(BUF_BYTES)};
  assign fc_levels    = {16'(NUM_DESC / 16), 16'(RESUME_GAP)};

  rx_ring_desc_tab #(.NUM_DESC(NUM_DESC), .ADDR_W(ADDR_W)) u_tab (
    .clk      (clk),
    .sw_wr_en (dsc_wr_en),
    .sw_idx   (dsc_wr_idx),
    .sw_addr  (dsc_wr_addr),
    .sw_stat  (preload_stat),
    .hw_wr_en (done_en),
    .hw_idx   (cur_idx),
    .hw_stat  (done_stat),
    .rd_idx   (dsc_rd_idx),
    .rd_addr  (dsc_rd_addr),
    .rd_stat  (dsc_rd_stat),
    .cur_idx  (cur_idx),
    .cur_addr (cur_buf_addr)
  );

  rx_ring_seq #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .align_en    (align_en),
    .ring_full   (ring_full),
    .buf_addr    (cur_buf_addr),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_last     (in_last),
    .in_ready    (in_ready),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .done_en     (done_en),
    .done_stat   (done_stat),
    .drop_pulse  (drop_pulse)
  );

  rx_ring_flow #(.NUM_DESC(NUM_DESC), .RESUME_GAP(RESUME_GAP)) u_flow (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv         (done_en),
    .cons_wr_en  (cons_wr_en),
    .cons_wr_val (cons_wr_val),
    .drop_pulse  (drop_pulse),
    .prod_q      (prod_idx),
    .cons_q      (cons_idx),
    .ring_full   (ring_full),
    .xoff_q      (xoff),
    .drop_q      (drop_cnt)
  );
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int NUM_DESC   = 256,
  parameter int BUF_BYTES  = 2048,
  parameter int ADDR_W     = 32,
  parameter int RESUME_GAP = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       prod_idx,
  input logic [15:0]       cons_idx,
  input logic              xoff,
  input logic [15:0]       drop_cnt,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [ADDR_W-1:0] cur_buf_addr
);
  localparam int PAUSE_LVL  = NUM_DESC / 16;
  localparam int RESUME_LVL = PAUSE_LVL + RESUME_GAP;

  logic [15:0] used_c;
  logic [16:0] free_c;
  assign used_c = prod_idx - cons_idx;
  assign free_c = 17'(NUM_DESC) - {1'b0, used_c};

  p_prod_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prod_idx == $past(prod_idx)) || (prod_idx == $past(prod_idx) + 16'd1));

  p_occupancy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    used_c <= 16'(NUM_DESC));

  p_drop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + 16'd1));

  p_xoff_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (free_c <= 17'(PAUSE_LVL)) |=> xoff);

  p_xoff_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff && free_c <= 17'(RESUME_LVL)) |=> xoff);

  p_xoff_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!xoff && free_c > 17'(PAUSE_LVL)) |=> !xoff);

  p_wr_in_buf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ((mem_wr_addr - cur_buf_addr) < ADDR_W'(BUF_BYTES)));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(
  .NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .RESUME_GAP(RESUME_GAP)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .prod_idx     (prod_idx),
  .cons_idx     (cons_idx),
  .xoff         (xoff),
  .drop_cnt     (drop_cnt),
  .mem_wr_en    (mem_wr_en),
  .mem_wr_addr  (mem_wr_addr),
  .cur_buf_addr (cur_buf_addr)
);

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;
  localparam int ND = 32;
  localparam int BB = 16;
  localparam int AW = 32;
  localparam int IW = 5;
  localparam int GAP = 5;
  localparam logic [31:0] BASE = 32'h100;

  logic          clk, rst_n, align_en;
  logic          dsc_wr_en;
  logic [IW-1:0] dsc_wr_idx, dsc_rd_idx;
  logic [AW-1:0] dsc_wr_addr, dsc_rd_addr;
  logic [31:0]   dsc_rd_stat;
  logic          cons_wr_en;
  logic [15:0]   cons_wr_val, prod_idx, drop_cnt;
  logic          in_valid, in_last, in_ready;
  logic [7:0]    in_data;
  logic          mem_wr_en;
  logic [AW-1:0] mem_wr_addr;
  logic [7:0]    mem_wr_data;
  logic          xoff;
  logic [31:0]   ring_geom, fc_levels;

  rx_ring_writer #(.NUM_DESC(ND), .BUF_BYTES(BB), .ADDR_W(AW), .RESUME_GAP(GAP)) i_rx_ring_writer (
    .clk(clk), .rst_n(rst_n), .align_en(align_en),
    .dsc_wr_en(dsc_wr_en), .dsc_wr_idx(dsc_wr_idx), .dsc_wr_addr(dsc_wr_addr),
    .dsc_rd_idx(dsc_rd_idx), .dsc_rd_addr(dsc_rd_addr), .dsc_rd_stat(dsc_rd_stat),
    .cons_wr_en(cons_wr_en), .cons_wr_val(cons_wr_val), .prod_idx(prod_idx),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .xoff(xoff), .drop_cnt(drop_cnt), .ring_geom(ring_geom), .fc_levels(fc_levels)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  bmem [0:1023];
  int          wr_total, oob_total;
  logic [31:0] exp_lo, exp_hi;

  always @(posedge clk) begin
    if (rst_n && mem_wr_en) begin
      bmem[mem_wr_addr[9:0]] <= mem_wr_data;
      wr_total <= wr_total + 1;
      if (mem_wr_addr < exp_lo || mem_wr_addr >= exp_hi) oob_total <= oob_total + 1;
    end
  end

  int total, bad;
  bit done_flag;
  int exp_prod, exp_cons, exp_drop;
  bit exp_x;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'(seed * 37 + k * 11 + 5);
  endfunction

  task automatic send_frame(input int n, input int seed);
    bit r;
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1;
      in_data  = pat(seed, k);
      in_last  = (k == n - 1);
      do begin
        r = in_ready;
        @(negedge clk);
      end while (!r);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic step_xoff_model();
    int fr;
    fr = ND - (exp_prod - exp_cons);
    if (exp_x) exp_x = (fr <= ND / 16 + GAP);
    else       exp_x = (fr <= ND / 16);
  endtask

  task automatic do_frame(input int n, input bit al, input bit drop);
    int idx, pad, stored, w0, o0, seed;
    bit tr;
    logic [31:0] lo, exp_stat;
    idx  = exp_prod % ND;
    lo   = BASE + 32'(idx * BB);
    exp_lo = lo;
    exp_hi = lo + BB;
    w0 = wr_total;
    o0 = oob_total;
    seed = n + 100 * int'(al) + exp_prod;
    align_en = al;
    dsc_rd_idx = IW'(idx);
    #1;
    exp_stat = dsc_rd_stat;
    @(negedge clk);
    send_frame(n, seed);
    dsc_rd_idx = IW'(idx);
    #1;
    if (drop) begin
      exp_drop++;
      chk(drop_cnt == 16'(exp_drop), "R5 drop count", drop_cnt, exp_drop);
      chk(prod_idx == 16'(exp_prod), "R5 prod held", prod_idx, exp_prod);
      chk(wr_total == w0, "R5 no writes", wr_total - w0, 0);
      chk(dsc_rd_stat == exp_stat, "R5 desc unchanged", dsc_rd_stat, exp_stat);
    end else begin
      pad    = al ? 2 : 0;
      tr     = (n + pad > BB);
      stored = tr ? BB : n + pad;
      exp_prod++;
      exp_stat = (32'(stored) << 16) | 32'h6000 | (tr ? 32'h200 : 32'h0);
      chk(prod_idx == 16'(exp_prod), "R3 prod step", prod_idx, exp_prod);
      chk(dsc_rd_stat == exp_stat, tr ? "R7 trunc status" : "R3 status", dsc_rd_stat, exp_stat);
      chk(wr_total - w0 == stored, "R7 write count", wr_total - w0, stored);
      chk(oob_total == o0, "R7 in buffer", oob_total - o0, 0);
      if (al) begin
        chk(bmem[lo[9:0]] == 8'h00 && bmem[lo[9:0] + 10'd1] == 8'h00, "R2 pad zero",
            {bmem[lo[9:0]], bmem[lo[9:0] + 10'd1]}, 0);
      end
      for (int k = 0; k < stored - pad; k++) begin
        chk(bmem[lo[9:0] + 10'(pad + k)] == pat(seed, k), "R2 data offset",
            bmem[lo[9:0] + 10'(pad + k)], pat(seed, k));
      end
    end
  endtask

  task automatic consume_to(input int v);
    cons_wr_en  = 1'b1;
    cons_wr_val = 16'(v);
    @(negedge clk);
    cons_wr_en  = 1'b0;
    exp_cons    = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; align_en = 1'b0; dsc_wr_en = 1'b0; dsc_wr_idx = '0; dsc_wr_addr = '0;
    dsc_rd_idx = '0; cons_wr_en = 1'b0; cons_wr_val = '0; in_valid = 1'b0; in_data = '0;
    in_last = 1'b0; exp_lo = '0; exp_hi = '0;
    exp_prod = 0; exp_cons = 0; exp_drop = 0; exp_x = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(prod_idx == 16'd0, "R9 prod", prod_idx, 0);
    chk(drop_cnt == 16'd0, "R9 drop", drop_cnt, 0);
    chk(xoff == 1'b0, "R9 xoff", xoff, 0);
    chk(in_ready == 1'b0 && mem_wr_en == 1'b0, "R9 idle", {in_ready, mem_wr_en}, 0);
    // R8 geometry
    chk(ring_geom == {16'(ND), 16'(BB)}, "R8 geom", ring_geom, {16'(ND), 16'(BB)});
    chk(fc_levels == {16'(ND / 16), 16'(GAP)}, "R8 levels", fc_levels, {16'(ND / 16), 16'(GAP)});
    // R1 preload
    for (int i = 0; i < ND; i++) begin
      dsc_wr_en = 1'b1; dsc_wr_idx = IW'(i); dsc_wr_addr = BASE + 32'(i * BB);
      @(negedge clk);
    end
    dsc_wr_en = 1'b0;
    for (int i = 0; i < ND; i++) begin
      dsc_rd_idx = IW'(i);
      #1;
      chk(dsc_rd_stat == ((32'(BB) << 16) | 32'h8000), "R1 preload status",
          dsc_rd_stat, (32'(BB) << 16) | 32'h8000);
      chk(dsc_rd_addr == BASE + 32'(i * BB), "R1 preload addr", dsc_rd_addr, BASE + 32'(i * BB));
    end
    @(negedge clk);
    // length sweep, padded then unpadded (R2 R3 R7), consuming each frame (R4)
    for (int a = 1; a >= 0; a--) begin
      for (int n = 1; n <= 20; n++) begin
        do_frame(n, a[0], 1'b0);
        consume_to(exp_prod);
        chk(xoff == 1'b0, "R4 empty ring no pause", xoff, 0);
      end
    end
    // fill to full (R6), then overflow (R5)
    for (int f = 0; f < ND; f++) begin
      do_frame(3, 1'b1, 1'b0);
      step_xoff_model();
      chk(xoff == exp_x, "R6 pause on fill", xoff, exp_x);
    end
    do_frame(5, 1'b1, 1'b1);
    chk(xoff == 1'b1, "R6 pause held when full", xoff, 1);
    // drain one at a time (R6 hysteresis, R4)
    for (int d = 0; d < ND; d++) begin
      consume_to(exp_cons + 1);
      step_xoff_model();
      chk(xoff == exp_x, "R6 pause on drain", xoff, exp_x);
    end
    // freed descriptor reused (R4)
    do_frame(4, 1'b0, 1'b0);
    chk(drop_cnt == 16'(exp_drop), "R4 no drop after drain", drop_cnt, exp_drop);
    done_flag = 1'b1;
    finish_run();
  end
endmodule